// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Controller

This block generates system resets from two active-low push-button lines and from a supply-low flag. A reset from the buttons needs both buttons held down together, without a break, for a long setup time. That time is chosen by a three-level strap, so a short or accidental press never resets the system. When the setup time completes, two reset outputs assert in the same cycle. One output is active high and the other is active low, and each has its own pulse length.

The supply-low flag comes from an external comparator. While it is set, both outputs stay active. Once it clears, each output stays active for its own pulse length. The same path also produces the power-on reset, because the synchronized flag starts in the asserted state.

All timing counts ticks of a timer clock enable. The pulse length of the active-high output is taken from an input value. The pulse length of the active-low output is a build-time choice between two constants. After a pulse ends, a quiet gap must pass before the buttons can start a new pulse.

Top module: `lp_reset_ctrl`

## Requirements
- R1: When both button lines are low together without a break, a reset is generated. The two outputs become active on the second clock after the setup count reaches the selected number of ticks (2 cycles of input synchronization, then the count).
- R2: The delay-select value is captured only while rst_n is low and is ignored afterwards. Encoding: 2'b00 selects SETUP_LO_TK, 2'b01 and 2'b10 select SETUP_MID_TK, and 2'b11 selects SETUP_HI_TK.
- R3: If either button goes high before the setup count completes, no reset is produced. The next press counts again from zero.
- R4: A reset started by the buttons makes both outputs active in the same clock cycle.
- R5: rst_hi_o is active when 1. rst_lo_n_o is active when 0.
- R6: A button-started pulse on rst_lo_n_o lasts PULSE2_SHORT_TK ticks, or PULSE2_LONG_TK ticks when PULSE2_LONG is 1.
- R7: A button-started pulse on rst_hi_o lasts plen1_i ticks. A value of 0 is treated as 1.
- R8: While supply_low_i is 1, both outputs are active. After it returns to 0, each output stays active for its own pulse length plus the two synchronizer cycles.
- R9: During reset both outputs are active. After rst_n rises, they act as if a supply-low condition had just cleared.
- R10: After a pulse ends, that output waits GAP_TK ticks before a new pulse may start. A setup completion that arrives while either output is active or in its gap is discarded.
- R11: Counting advances only on cycles where tick_en_i is 1. With the tick held low, a press never completes.
- R12: After a button-started reset, at least one button must go high before a new setup count can begin. A continuous hold gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the capture window for the delay select |
| btn0_n_i | input | 1 | First push button, active low, asynchronous |
| btn1_n_i | input | 1 | Second push button, active low, asynchronous |
| dly_sel_i | input | 2 | Encoded three-level setup-time strap |
| supply_low_i | input | 1 | Supply-low flag from an external comparator, active high |
| tick_en_i | input | 1 | Timer tick enable; all durations count these |
| plen1_i | input | PLEN1_W | Pulse length of rst_hi_o in ticks |
| rst_hi_o | output | 1 | Active-high reset output |
| rst_lo_n_o | output | 1 | Active-low reset output |

## Verification
A setup counter that is off by one, or that fails to clear on release, shows up as the first active output cycle landing a few cycles early or late after a press. It can also show up as a reset from a press that should have been too short. Such faults therefore appear within one setup window. A pulse channel stuck in the wrong state shows up as a wrong count of active cycles on its own output, or as a second rising edge during a held press or a busy window. Either is visible by the end of the longer pulse plus its gap. A wrong strap capture appears as the latency of the first press taken after reset.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   localparam int NUM_CH = 2;

   typedef enum logic [1:0] {
      PS_IDLE   = 2'd0,
      PS_ACTIVE = 2'd1,
      PS_GAP    = 2'd2
   } pulse_st_e;

   typedef enum logic [1:0] {
      STRAP_LOW  = 2'b00,
      STRAP_OPEN = 2'b01,
      STRAP_ALT  = 2'b10,
      STRAP_HIGH = 2'b11
   } strap_e;

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stage1;
   logic [W-1:0] stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= RST_VAL;
         stage2 <= RST_VAL;
      end else begin
         stage1 <= d_i;
         stage2 <= stage1;
      end
   end

   assign q_o = stage2;

endmodule

// File: rtl/lpr_press.sv
module lpr_press #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          btn_a_n,
   input  logic          btn_b_n,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          fire_o
);

   logic          both_low;
   logic          armed;
   logic [CW-1:0] cnt;
   logic          at_end;

   assign both_low = !btn_a_n && !btn_b_n;
   assign at_end   = (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (!both_low) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (armed && tick) begin
         if (at_end) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign fire_o = both_low && armed && tick && at_end;

   // R1: a completion needs the buttons already down in the cycle before
   p_fire_after_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(both_low));

   // R12: one completion per hold
   p_single_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

   // R3: a release stops any completion in the following cycle
   p_release_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !both_low |=> !fire_o || $past(both_low));

endmodule

// File: rtl/lpr_pulse.sv
module lpr_pulse
   import lpr_pkg::*;
#(
   parameter int PW     = 8,
   parameter int GAP_TK = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          start,
   input  logic          tick,
   input  logic [PW-1:0] len,
   output logic          act_o,
   output logic          ready_o
);

   localparam logic [PW-1:0] GAP_LAST = PW'(GAP_TK - 1);

   pulse_st_e     state;
   logic [PW-1:0] cnt;
   logic [PW-1:0] len_eff;

   assign len_eff = (len == '0) ? PW'(1) : len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_ACTIVE;
         cnt   <= '0;
      end else if (hold) begin
         state <= PS_ACTIVE;
         cnt   <= '0;
      end else begin
         case (state)
            PS_IDLE: begin
               if (start) begin
                  state <= PS_ACTIVE;
                  cnt   <= '0;
               end
            end
            PS_ACTIVE: begin
               if (tick) begin
                  if (cnt == len_eff - 1'b1) begin
                     state <= PS_GAP;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PS_GAP: begin
               if (tick) begin
                  if (cnt == GAP_LAST) begin
                     state <= PS_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               state <= PS_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign act_o   = (state == PS_ACTIVE);
   assign ready_o = (state == PS_IDLE);

   // R8: a held supply-low keeps the output active
   p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> act_o);

   // R10: a finished pulse is followed by a quiet cycle unless supply-low
   p_gap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_o) && !hold |=> !act_o);

   // R10: an accepted start from idle produces a pulse
   p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start && ready_o |=> act_o);

endmodule

// File: rtl/lp_reset_ctrl.sv
module lp_reset_ctrl
   import lpr_pkg::*;
#(
   parameter int SETUP_LO_TK     = 2000,
   parameter int SETUP_MID_TK    = 6000,
   parameter int SETUP_HI_TK     = 10000,
   parameter int PULSE2_SHORT_TK = 210,
   parameter int PULSE2_LONG_TK  = 360,
   parameter bit PULSE2_LONG     = 1'b0,
   parameter int GAP_TK          = 10,
   parameter int PLEN1_W         = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               btn0_n_i,
   input  logic               btn1_n_i,
   input  logic [1:0]         dly_sel_i,
   input  logic               supply_low_i,
   input  logic               tick_en_i,
   input  logic [PLEN1_W-1:0] plen1_i,
   output logic               rst_hi_o,
   output logic               rst_lo_n_o
);

   localparam int P2_LEN    = PULSE2_LONG ? PULSE2_LONG_TK : PULSE2_SHORT_TK;
   localparam int CW        = $clog2(SETUP_HI_TK + 1);
   localparam int PLEN1_MAX = (1 << PLEN1_W) - 1;
   localparam int PM_A      = (PLEN1_MAX > P2_LEN) ? PLEN1_MAX : P2_LEN;
   localparam int PM_B      = (PM_A > GAP_TK) ? PM_A : GAP_TK;
   localparam int PW        = $clog2(PM_B + 1);

   if (SETUP_LO_TK < 2) begin : g_bad_lo
      $error("SETUP_LO_TK must be at least 2");
   end
   if ((SETUP_MID_TK < SETUP_LO_TK) || (SETUP_HI_TK < SETUP_MID_TK)) begin : g_bad_order
      $error("setup times must be ordered LO <= MID <= HI");
   end
   if (GAP_TK < 1) begin : g_bad_gap
      $error("GAP_TK must be at least 1");
   end
   if (P2_LEN < 1) begin : g_bad_p2
      $error("second pulse length must be at least 1");
   end

   // input synchronizers; the supply flag starts asserted for power-on reset
   logic [1:0] btn_s;
   logic       uv_s;

   lpr_sync #(.W(2), .RST_VAL(2'b11)) u_btn_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({btn1_n_i, btn0_n_i}),
      .q_o   (btn_s)
   );

   lpr_sync #(.W(1), .RST_VAL(1'b1)) u_uv_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (supply_low_i),
      .q_o   (uv_s)
   );

   // strap captured while in reset only
   strap_e        strap_q;
   logic [CW-1:0] limit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_q <= strap_e'(dly_sel_i);
      end
   end

   always_comb begin
      case (strap_q)
         STRAP_LOW:  limit = CW'(SETUP_LO_TK);
         STRAP_HIGH: limit = CW'(SETUP_HI_TK);
         default:    limit = CW'(SETUP_MID_TK);
      endcase
   end

   logic fire;

   lpr_press #(.CW(CW)) u_press (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_a_n (btn_s[0]),
      .btn_b_n (btn_s[1]),
      .tick    (tick_en_i),
      .limit   (limit),
      .fire_o  (fire)
   );

   // pulse channels: 0 drives the active-high output, 1 the active-low output
   logic [PW-1:0]     len_ch [NUM_CH];
   logic [NUM_CH-1:0] act_ch;
   logic [NUM_CH-1:0] ready_ch;
   logic              start_all;

   assign len_ch[0] = PW'(plen1_i);
   assign len_ch[1] = PW'(P2_LEN);
   assign start_all = fire && (&ready_ch);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      lpr_pulse #(.PW(PW), .GAP_TK(GAP_TK)) u_pulse (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold    (uv_s),
         .start   (start_all),
         .tick    (tick_en_i),
         .len     (len_ch[ch]),
         .act_o   (act_ch[ch]),
         .ready_o (ready_ch[ch])
      );
   end

   assign rst_hi_o   = act_ch[0];
   assign rst_lo_n_o = ~act_ch[1];

   // R4: an accepted press drives both outputs active in the next cycle
   p_joint_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_all |=> (rst_hi_o && !rst_lo_n_o));

   // R10: a completion while either channel is busy changes no idle output
   p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !(&ready_ch) && !uv_s && !rst_hi_o |=> !rst_hi_o);

endmodule

// File: tb/sim_lp_reset_ctrl.sv
module sim_lp_reset_ctrl;

   localparam int LO  = 20;
   localparam int MID = 40;
   localparam int HI  = 60;
   localparam int P2  = 30;
   localparam int GAP = 8;
   localparam int PLW = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           b0 = 1'b1;
   logic           b1 = 1'b1;
   logic [1:0]     dly = 2'b01;
   logic           slow = 1'b0;
   logic           tick = 1'b1;
   logic [PLW-1:0] plen = 6'd12;
   logic           rhi;
   logic           rlo_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   lp_reset_ctrl #(
      .SETUP_LO_TK(LO), .SETUP_MID_TK(MID), .SETUP_HI_TK(HI),
      .PULSE2_SHORT_TK(P2), .PULSE2_LONG_TK(50), .PULSE2_LONG(1'b0),
      .GAP_TK(GAP), .PLEN1_W(PLW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .btn0_n_i(b0), .btn1_n_i(b1),
      .dly_sel_i(dly), .supply_low_i(slow), .tick_en_i(tick),
      .plen1_i(plen), .rst_hi_o(rhi), .rst_lo_n_o(rlo_n)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // reset with a strap value, check reset state and power-on pulse widths
   task automatic do_reset(input logic [1:0] strap, input bit check_por);
      int hi_w;
      int lo_w;
      @(negedge clk);
      rst_n = 1'b0;
      dly   = strap;
      slow  = 1'b0;
      b0    = 1'b1;
      b1    = 1'b1;
      idle(4);
      if (check_por) begin
         check(rhi == 1'b1, "R9 reset state rst_hi", rhi, 1);
         check(rlo_n == 1'b0, "R9 R5 reset state rst_lo_n", rlo_n, 0);
      end
      rst_n = 1'b1;
      hi_w = 0;
      lo_w = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (rhi) hi_w++;
         if (!rlo_n) lo_w++;
      end
      if (check_por) begin
         check(hi_w == int'(plen) + 1, "R9 power-on width rst_hi", hi_w, int'(plen) + 1);
         check(lo_w == P2 + 1, "R9 power-on width rst_lo_n", lo_w, P2 + 1);
      end
   endtask

   // press both, check latency and joint start, then widths
   task automatic press_measure(input int lim, input int exp_hi, input int exp_lo, input string tag);
      int k;
      int hi_w;
      int lo_w;
      idle(60);
      b0 = 1'b0;
      b1 = 1'b0;
      k  = 0;
      for (int i = 0; i < lim + 30; i++) begin
         @(negedge clk);
         k++;
         if (rhi || !rlo_n) break;
      end
      check(k == lim + 2, {tag, " R1 R2 latency"}, k, lim + 2);
      check(rhi && !rlo_n, {tag, " R4 R5 joint start"}, {rhi, rlo_n}, 2);
      hi_w = rhi ? 1 : 0;
      lo_w = !rlo_n ? 1 : 0;
      for (int i = 0; i < P2 + 30; i++) begin
         @(negedge clk);
         if (rhi) hi_w++;
         if (!rlo_n) lo_w++;
      end
      check(hi_w == exp_hi, {tag, " R7 rst_hi width"}, hi_w, exp_hi);
      check(lo_w == exp_lo, {tag, " R6 rst_lo_n width"}, lo_w, exp_lo);
      b0 = 1'b1;
      b1 = 1'b1;
      idle(40);
   endtask

   task automatic t_por();
      do_reset(2'b01, 1'b1);
   endtask

   task automatic t_press_mid();
      press_measure(MID, 12, P2, "mid");
   endtask

   task automatic t_zero_len();
      plen = '0;
      press_measure(MID, 1, P2, "zero-len");
      plen = 6'd12;
   endtask

   task automatic t_short_press();
      int seen;
      idle(60);
      seen = 0;
      b0 = 1'b0;
      b1 = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (rhi || !rlo_n) seen++;
      end
      b1 = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (rhi || !rlo_n) seen++;
      end
      check(seen == 0, "R3 short press ignored", seen, 0);
      b1 = 1'b1;
      b0 = 1'b1;
      // partial press, short release, then full press counts from zero
      b0 = 1'b0;
      b1 = 1'b0;
      idle(30);
      b0 = 1'b1;
      idle(5);
      press_measure(MID, 12, P2, "R3 restart");
   endtask

   task automatic t_rearm();
      int rises;
      bit prev;
      idle(60);
      rises = 0;
      prev  = rhi;
      b0 = 1'b0;
      b1 = 1'b0;
      for (int i = 0; i < 4 * MID; i++) begin
         @(negedge clk);
         if (rhi && !prev) rises++;
         prev = rhi;
      end
      check(rises == 1, "R12 continuous hold gives one pulse", rises, 1);
      b0 = 1'b1;
      b1 = 1'b1;
      idle(40);
   endtask

   task automatic t_tick_gate();
      int seen;
      idle(60);
      tick = 1'b0;
      seen = 0;
      b0 = 1'b0;
      b1 = 1'b0;
      for (int i = 0; i < 3 * MID; i++) begin
         @(negedge clk);
         if (rhi || !rlo_n) seen++;
      end
      check(seen == 0, "R11 no tick no reset", seen, 0);
      b0 = 1'b1;
      b1 = 1'b1;
      idle(5);
      tick = 1'b1;
      idle(10);
   endtask

   task automatic t_supply_low();
      int bad;
      int hi_w;
      int lo_w;
      idle(60);
      slow = 1'b1;
      idle(3);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!rhi || rlo_n) bad++;
      end
      check(bad == 0, "R8 held active during supply low", bad, 0);
      slow = 1'b0;
      hi_w = 0;
      lo_w = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (rhi) hi_w++;
         if (!rlo_n) lo_w++;
      end
      check(hi_w == int'(plen) + 1, "R8 rst_hi extension", hi_w, int'(plen) + 1);
      check(lo_w == P2 + 1, "R8 rst_lo_n extension", lo_w, P2 + 1);
   endtask

   task automatic t_busy();
      int rises;
      bit prev;
      do_reset(2'b00, 1'b0);
      press_measure(LO, 12, P2, "lo");
      idle(60);
      b0 = 1'b0;
      b1 = 1'b0;
      for (int i = 0; i < LO + 30; i++) begin
         @(negedge clk);
         if (rhi) break;
      end
      b0 = 1'b1;
      b1 = 1'b1;
      idle(3);
      b0 = 1'b0;
      b1 = 1'b0;
      rises = 0;
      prev  = rhi;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (rhi && !prev) rises++;
         prev = rhi;
      end
      check(rises == 0, "R10 press during busy window discarded", rises, 0);
      b0 = 1'b1;
      b1 = 1'b1;
      idle(40);
   endtask

   task automatic t_strap_hi();
      do_reset(2'b11, 1'b0);
      dly = 2'b00;
      press_measure(HI, 12, P2, "R2 high strap held after reset");
      do_reset(2'b10, 1'b0);
      dly = 2'b11;
      press_measure(MID, 12, P2, "R2 alt code as open");
   endtask

   initial begin
      #(8 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      t_por();
      t_press_mid();
      t_zero_len();
      t_short_press();
      t_rearm();
      t_tick_gate();
      t_supply_low();
      t_busy();
      t_strap_hi();
      finish_up();
   end

endmodule